// File: doc/BRIEF.md
# Timed-unlock EEPROM access controller

This block lets a processor reach a 512-byte nonvolatile data array through four byte-wide registers: two halves of an address pointer, a data byte and a control byte. Reads finish at once; the data byte is loaded from the addressed location and the processor is held for a few cycles. Programming is guarded by an unlock step. Software first sets an arm bit, and the arm bit clears itself after a short window. A fire bit written while the arm bit is still set starts a self-timed operation. While that operation runs, the fire bit reads back as one.

Three programming kinds are offered: erase the byte to all ones, write (clear bits only), or erase-then-write as one step. The combined kind takes twice as long as the other two. During an operation the pointer and the mode field are frozen and reads are refused. An external busy input from the flash self-programming engine blocks any start. A level interrupt reports that the array is idle, and a stall output holds the processor after a read or a successful start. The array is modelled inside the block as a byte memory.

Top module: `nvm_access_ctl`

## Requirements
- R1: Register select on `bus_sel`: 0 is address bits 7..0, 1 is the address high byte (bit 0 = address bit 8, bits 7..1 read zero), 2 is the data byte, 3 is control. Control bits: 0 read request (reads zero), 1 program busy/fire, 2 arm, 3 interrupt enable, 5..4 mode, 7..6 read zero.
- R2: Once the arm bit is set by a control write, it reads one for exactly ARM_WIN (4) cycles and then clears by itself.
- R3: A control write with bit 1 set starts an operation only if the arm bit is set at that edge, so a fire 1 to 4 cycles after the arm write starts and one 5 cycles after does not. A fire with the arm bit clear has no effect.
- R4: Mode 00 stores the data byte, mode 01 sets the byte to 0xFF, mode 10 stores the old byte ANDed with the data byte, and mode 11 starts nothing and leaves the array unchanged.
- R5: Bit 1 of control reads one for CYC_ATOMIC cycles in mode 00 and CYC_ATOMIC/2 cycles in modes 01 and 10, then clears; the array byte changes when it clears.
- R6: While an operation runs, control writes leave the mode field unchanged.
- R7: A read request loads the data byte from the addressed location at the write edge and raises `cpu_stall` for RD_STALL (4) cycles.
- R8: A successful start raises `cpu_stall` for WR_STALL (2) cycles.
- R9: While an operation runs, read requests are refused (no load, no stall) and address writes are ignored.
- R10: `ready_irq` is high exactly while the interrupt enable is set and no operation runs.
- R11: While `flash_busy` is high, a fire request starts nothing.
- R12: Reset clears the data byte, the arm bit, the interrupt enable and the stall; it returns the mode field to 00 when idle. A running operation continues through reset, keeps its mode and completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also times the programming operations |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_sel | input | 2 | Register select |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Read value of the selected register |
| flash_busy | input | 1 | Flash self-programming in progress; blocks starts |
| cpu_stall | output | 1 | Hold request to the processor |
| ready_irq | output | 1 | Level interrupt: enabled and idle |

## Verification
The bench places the fire write at the fourth and at the fifth cycle after the arm write. A controller whose window is off by one would either lose a legal write or accept a late one. The bench measures the busy time of each mode cycle by cycle, so swapped durations or a commit at start rather than at the end show up. It writes the pointer, the mode and a read request during an operation to catch a design that lets them through, and it asserts reset mid-operation and checks that the erase still lands. The write-only vector leaves bits that the combined mode would store, so confusing those two modes changes the read-back byte.

// File: rtl/nvm_pkg.sv
package nvm_pkg;

    localparam int unsigned NVM_AW    = 9;
    localparam int unsigned NVM_DEPTH = 1 << NVM_AW;

    typedef enum logic [1:0] {
        MODE_BOTH  = 2'b00,
        MODE_ERASE = 2'b01,
        MODE_WRITE = 2'b10,
        MODE_RSVD  = 2'b11
    } nvm_mode_e;

    typedef enum logic [1:0] {
        SEL_ADDR_LO = 2'd0,
        SEL_ADDR_HI = 2'd1,
        SEL_DATA    = 2'd2,
        SEL_CTRL    = 2'd3
    } nvm_sel_e;

    localparam int unsigned CB_READ = 0;
    localparam int unsigned CB_FIRE = 1;
    localparam int unsigned CB_ARM  = 2;
    localparam int unsigned CB_IE   = 3;
    localparam int unsigned CB_MODE = 4;

    typedef struct packed {
        nvm_mode_e          mode;
        logic [NVM_AW-1:0]  addr;
        logic [7:0]         data;
    } nvm_op_t;

    function automatic logic [7:0] nvm_next_byte(nvm_mode_e m, logic [7:0] old_b, logic [7:0] d);
        case (m)
            MODE_BOTH:  return d;
            MODE_ERASE: return 8'hFF;
            MODE_WRITE: return old_b & d;
            default:    return old_b;
        endcase
    endfunction

    function automatic logic nvm_mode_ok(nvm_mode_e m);
        return m != MODE_RSVD;
    endfunction

endpackage

// File: rtl/nvm_arm_window.sv
module nvm_arm_window #(
    parameter int unsigned WIN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic armed
);
    localparam int unsigned CW = $clog2(WIN + 1);

    logic [CW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst)                left_q <= '0;
        else if (clr)           left_q <= '0;
        else if (set)           left_q <= CW'(WIN);
        else if (left_q != '0)  left_q <= left_q - CW'(1);
    end

    assign armed = (left_q != '0);
endmodule

// File: rtl/nvm_op_timer.sv
module nvm_op_timer
    import nvm_pkg::*;
#(
    parameter int unsigned CYC_ATOMIC = 26368
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  nvm_op_t start_op,
    output logic    busy,
    output logic    commit,
    output nvm_op_t cur_op
);
    localparam int unsigned CYC_HALF = CYC_ATOMIC / 2;
    localparam int unsigned CW       = $clog2(CYC_ATOMIC + 1);

    logic [CW-1:0] left_q;
    nvm_op_t       op_q;

    // A running operation survives reset; only an idle timer is cleared.
    always_ff @(posedge clk) begin
        if (rst && left_q == '0) begin
            left_q <= '0;
        end else if (start && !rst) begin
            left_q <= (start_op.mode == MODE_BOTH) ? CW'(CYC_ATOMIC) : CW'(CYC_HALF);
        end else if (left_q != '0) begin
            left_q <= left_q - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (start && !rst) op_q <= start_op;
    end

    assign busy   = (left_q != '0);
    assign commit = (left_q == CW'(1));
    assign cur_op = op_q;
endmodule

// File: rtl/nvm_stall_ctr.sv
module nvm_stall_ctr #(
    parameter int unsigned RD_STALL = 4,
    parameter int unsigned WR_STALL = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic load_rd,
    input  logic load_wr,
    output logic stall
);
    localparam int unsigned MAXC = (RD_STALL > WR_STALL) ? RD_STALL : WR_STALL;
    localparam int unsigned CW   = $clog2(MAXC + 1);

    logic [CW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst)                left_q <= '0;
        else if (load_rd)       left_q <= CW'(RD_STALL);
        else if (load_wr)       left_q <= CW'(WR_STALL);
        else if (left_q != '0)  left_q <= left_q - CW'(1);
    end

    assign stall = (left_q != '0);
endmodule

// File: rtl/nvm_byte_array.sv
module nvm_byte_array #(
    parameter int unsigned DEPTH = 512,
    parameter int unsigned AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [7:0]    rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [7:0]    rdata_b
);
    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata_a = cells[raddr_a];
    assign rdata_b = cells[raddr_b];
endmodule

// File: rtl/nvm_access_ctl.sv
module nvm_access_ctl
    import nvm_pkg::*;
#(
    parameter int unsigned CYC_ATOMIC = 26368,
    parameter int unsigned ARM_WIN    = 4,
    parameter int unsigned RD_STALL   = 4,
    parameter int unsigned WR_STALL   = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_wr,
    input  logic [1:0] bus_sel,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       flash_busy,
    output logic       cpu_stall,
    output logic       ready_irq
);
    localparam int unsigned VIEW_W = 16;

    nvm_sel_e          sel;
    logic              wr_lo, wr_hi, wr_data, wr_ctrl;
    nvm_mode_e         w_mode;
    logic              armed, op_busy, commit;
    logic              start_go, read_go, arm_set;
    logic [NVM_AW-1:0] addr_q;
    logic [7:0]        data_q;
    nvm_mode_e         mode_q;
    logic              ie_q;
    logic [VIEW_W-1:0] addr_view;
    logic [VIEW_W-1:0] addr_next_lo, addr_next_hi;
    nvm_op_t           new_op, cur_op;
    logic [7:0]        rd_byte, old_byte;

    assign sel     = nvm_sel_e'(bus_sel);
    assign wr_lo   = bus_wr && !rst && (sel == SEL_ADDR_LO);
    assign wr_hi   = bus_wr && !rst && (sel == SEL_ADDR_HI);
    assign wr_data = bus_wr && !rst && (sel == SEL_DATA);
    assign wr_ctrl = bus_wr && !rst && (sel == SEL_CTRL);
    assign w_mode  = nvm_mode_e'(bus_wdata[CB_MODE+1:CB_MODE]);

    // Start: armed, idle, no flash activity, legal mode (the mode written in this same access).
    assign start_go = wr_ctrl && bus_wdata[CB_FIRE] && armed && !op_busy
                      && !flash_busy && nvm_mode_ok(w_mode);
    assign read_go  = wr_ctrl && bus_wdata[CB_READ] && !op_busy;
    assign arm_set  = wr_ctrl && bus_wdata[CB_ARM] && !start_go;

    assign addr_view    = VIEW_W'(addr_q);
    assign addr_next_lo = {addr_view[VIEW_W-1:8], bus_wdata};
    assign addr_next_hi = {bus_wdata, addr_view[7:0]};

    always_ff @(posedge clk) begin
        if (wr_lo && !op_busy)      addr_q <= addr_next_lo[NVM_AW-1:0];
        else if (wr_hi && !op_busy) addr_q <= addr_next_hi[NVM_AW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)          data_q <= 8'h00;
        else if (read_go) data_q <= rd_byte;
        else if (wr_data) data_q <= bus_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            if (!op_busy) mode_q <= MODE_BOTH;
        end else if (wr_ctrl && !op_busy) begin
            mode_q <= w_mode;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          ie_q <= 1'b0;
        else if (wr_ctrl) ie_q <= bus_wdata[CB_IE];
    end

    assign new_op = '{mode: w_mode, addr: addr_q, data: data_q};

    nvm_arm_window #(.WIN(ARM_WIN)) arm_i (
        .clk   (clk),
        .rst   (rst),
        .set   (arm_set),
        .clr   (start_go),
        .armed (armed)
    );

    nvm_op_timer #(.CYC_ATOMIC(CYC_ATOMIC)) timer_i (
        .clk      (clk),
        .rst      (rst),
        .start    (start_go),
        .start_op (new_op),
        .busy     (op_busy),
        .commit   (commit),
        .cur_op   (cur_op)
    );

    nvm_stall_ctr #(.RD_STALL(RD_STALL), .WR_STALL(WR_STALL)) stall_i (
        .clk     (clk),
        .rst     (rst),
        .load_rd (read_go),
        .load_wr (start_go),
        .stall   (cpu_stall)
    );

    nvm_byte_array #(.DEPTH(NVM_DEPTH), .AW(NVM_AW)) array_i (
        .clk     (clk),
        .we      (commit),
        .waddr   (cur_op.addr),
        .wdata   (nvm_next_byte(cur_op.mode, old_byte, cur_op.data)),
        .raddr_a (addr_q),
        .rdata_a (rd_byte),
        .raddr_b (cur_op.addr),
        .rdata_b (old_byte)
    );

    always_comb begin
        case (sel)
            SEL_ADDR_LO: bus_rdata = addr_view[7:0];
            SEL_ADDR_HI: bus_rdata = addr_view[15:8];
            SEL_DATA:    bus_rdata = data_q;
            default:     bus_rdata = {2'b00, mode_q, ie_q, armed, op_busy, 1'b0};
        endcase
    end

    assign ready_irq = ie_q && !op_busy;
endmodule

// File: rtl/nvm_access_chk.sv
module nvm_access_chk (
    input logic       clk,
    input logic       rst,
    input logic       flash_busy,
    input logic       cpu_stall,
    input logic       ready_irq,
    input logic       armed,
    input logic       op_busy,
    input logic       ie,
    input logic [1:0] mode,
    input logic [8:0] addr
);
    // R3: an operation only begins from a cycle in which the arm bit was set
    a_r3_no_start_unarmed: assert property (@(posedge clk) disable iff (rst)
        (!armed && !op_busy) |=> !op_busy);

    // R11: flash activity blocks any start
    a_r11_flash_blocks: assert property (@(posedge clk) disable iff (rst)
        (flash_busy && !op_busy) |=> !op_busy);

    // R6: mode frozen while busy
    a_r6_mode_frozen: assert property (@(posedge clk) disable iff (rst)
        op_busy |=> $stable(mode));

    // R9: address frozen while busy
    a_r9_addr_frozen: assert property (@(posedge clk) disable iff (rst)
        op_busy |=> $stable(addr));

    // R8: a start always stalls the processor
    a_r8_start_stalls: assert property (@(posedge clk) disable iff (rst)
        $rose(op_busy) |-> cpu_stall);

    // R10: finishing with the interrupt enabled raises the interrupt
    a_r10_irq_on_done: assert property (@(posedge clk) disable iff (rst)
        ($fell(op_busy) && ie) |-> ready_irq);
endmodule

bind nvm_access_ctl nvm_access_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .flash_busy (flash_busy),
    .cpu_stall  (cpu_stall),
    .ready_irq  (ready_irq),
    .armed      (armed),
    .op_busy    (op_busy),
    .ie         (ie_q),
    .mode       (mode_q),
    .addr       (addr_q)
);

// File: tb/nvm_access_ctl_tb.sv
module nvm_access_ctl_tb_top;
    localparam int unsigned CYC = 40;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_sel = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       flash_busy = 1'b0;
    logic       cpu_stall;
    logic       ready_irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    logic       ie_b = 1'b0;

    always #4 clk = ~clk;

    nvm_access_ctl #(.CYC_ATOMIC(CYC)) dut_i (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .flash_busy(flash_busy),
        .cpu_stall(cpu_stall), .ready_irq(ready_irq)
    );

    // {mode[2], addr[9], pre[8], data[8], expected[8]}
    localparam logic [34:0] VECS [6] = '{
        {2'b00, 9'h000, 8'h5A, 8'h3C, 8'h3C},
        {2'b01, 9'h1FF, 8'h5A, 8'h00, 8'hFF},
        {2'b10, 9'h100, 8'hF0, 8'h3C, 8'h30},
        {2'b11, 9'h0AB, 8'h81, 8'h00, 8'h81},
        {2'b10, 9'h155, 8'hFF, 8'hA5, 8'hA5},
        {2'b01, 9'h0FF, 8'h00, 8'h77, 8'hFF}
    };

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        bus_wr = 1'b1; bus_sel = s; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [7:0] v);
        bus_sel = s;
        #1;
        v = bus_rdata;
    endtask

    function automatic logic [7:0] ctl(input logic [1:0] m, input logic [3:0] low);
        return {2'b00, m, ie_b, low[2:0]};
    endfunction

    task automatic set_addr(input logic [8:0] a);
        wr(2'd0, a[7:0]);
        wr(2'd1, {7'b0, a[8]});
    endtask

    task automatic arm_fire(input logic [1:0] m, input logic [7:0] d);
        wr(2'd2, d);
        wr(2'd3, ctl(m, 4'b0100));
        wr(2'd3, ctl(m, 4'b0010));
    endtask

    task automatic busy_cycles(output int n);
        logic [7:0] v;
        n = 0;
        for (int k = 0; k < 1000; k++) begin
            rd(2'd3, v);
            if (!v[1]) break;
            n++;
            @(negedge clk);
        end
    endtask

    task automatic stall_cycles(output int n);
        n = 0;
        for (int k = 0; k < 50; k++) begin
            if (!cpu_stall) break;
            n++;
            @(negedge clk);
        end
    endtask

    task automatic read_byte(input logic [8:0] a, output logic [7:0] v);
        set_addr(a);
        wr(2'd3, ctl(2'b00, 4'b0001));
        rd(2'd2, v);
    endtask

    function automatic int exp_dur(input logic [1:0] m);
        case (m)
            2'b00:   return CYC;
            2'b11:   return 0;
            default: return CYC / 2;
        endcase
    endfunction

    initial begin : watchdog
        for (int k = 0; k < 150000; k++) begin
            @(posedge clk);
            if (done) disable watchdog;
        end
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        logic [7:0] v;
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R12 reset state, R10 interrupt off, R1 register layout
        rd(2'd3, v);  check("R12 ctrl after reset", v, 8'h00);
        rd(2'd2, v);  check("R12 data after reset", v, 8'h00);
        check("R12 stall after reset", cpu_stall, 0);
        check("R10 irq with enable clear", ready_irq, 0);
        wr(2'd1, 8'hFF);
        rd(2'd1, v);  check("R1 addr high reserved bits", v, 8'h01);
        wr(2'd3, 8'hC0);
        rd(2'd3, v);  check("R1 ctrl reserved bits", v, 8'h00);

        // R4 R5 vector walk
        for (int i = 0; i < 6; i++) begin
            logic [34:0] e;
            e = VECS[i];
            set_addr(e[32:24]);
            arm_fire(2'b00, e[23:16]);
            busy_cycles(n);
            arm_fire(e[34:33], e[15:8]);
            busy_cycles(n);
            check($sformatf("R5 busy length vector %0d", i), n, exp_dur(e[34:33]));
            read_byte(e[32:24], v);
            check($sformatf("R4 stored byte vector %0d", i), v, e[7:0]);
        end

        // R7 read stall length and read enable bit reads zero
        set_addr(9'h000);
        wr(2'd3, ctl(2'b00, 4'b0001));
        stall_cycles(n);
        check("R7 read stall cycles", n, 4);
        rd(2'd3, v);  check("R7 read bit self-clears", v[0], 0);

        // R2 arm window, R3 late fire refused
        set_addr(9'h010);
        arm_fire(2'b00, 8'h00);
        busy_cycles(n);
        wr(2'd2, 8'h77);
        wr(2'd3, ctl(2'b00, 4'b0100));
        repeat (3) @(negedge clk);
        wr(2'd3, ctl(2'b00, 4'b0010));            // fire at arm edge + 4
        rd(2'd3, v);  check("R3 fire on fourth cycle starts", v[1], 1);
        stall_cycles(n);
        check("R8 start stall cycles", n, 2);
        busy_cycles(n);
        read_byte(9'h010, v);  check("R3 fourth-cycle write landed", v, 8'h77);

        wr(2'd2, 8'h99);
        wr(2'd3, ctl(2'b00, 4'b0100));
        rd(2'd3, v);  check("R2 arm set after write", v[2], 1);
        repeat (3) @(negedge clk);
        rd(2'd3, v);  check("R2 arm still set at cycle 4", v[2], 1);
        @(negedge clk);
        rd(2'd3, v);  check("R2 arm cleared after window", v[2], 0);
        wr(2'd3, ctl(2'b00, 4'b0010));            // fire at arm edge + 5
        rd(2'd3, v);  check("R3 fire on fifth cycle refused", v[1], 0);
        read_byte(9'h010, v);  check("R3 late fire left byte", v, 8'h77);

        // R3 fire without arm
        wr(2'd2, 8'h11);
        wr(2'd3, ctl(2'b00, 4'b0010));
        rd(2'd3, v);  check("R3 unarmed fire refused", v[1], 0);

        // R11 flash busy blocks start
        flash_busy = 1'b1;
        arm_fire(2'b00, 8'h22);
        rd(2'd3, v);  check("R11 start blocked by flash busy", v[1], 0);
        flash_busy = 1'b0;
        read_byte(9'h010, v);  check("R11 byte unchanged", v, 8'h77);

        // R6 R9 R10 behaviour during an operation
        ie_b = 1'b1;
        wr(2'd3, ctl(2'b00, 4'b0000));
        check("R10 irq when idle and enabled", ready_irq, 1);
        set_addr(9'h020);
        arm_fire(2'b00, 8'h5C);
        check("R10 irq low while busy", ready_irq, 0);
        wr(2'd3, ctl(2'b01, 4'b0000));
        rd(2'd3, v);  check("R6 mode write ignored while busy", v[5:4], 0);
        wr(2'd0, 8'h99);
        wr(2'd2, 8'hE1);
        repeat (3) @(negedge clk);
        wr(2'd3, ctl(2'b00, 4'b0001));
        check("R9 refused read does not stall", cpu_stall, 0);
        rd(2'd2, v);  check("R9 refused read leaves data", v, 8'hE1);
        busy_cycles(n);
        check("R10 irq after completion", ready_irq, 1);
        rd(2'd0, v);  check("R9 addr write ignored while busy", v, 8'h20);
        ie_b = 1'b0;
        read_byte(9'h020, v);  check("R9 operation used latched data", v, 8'h5C);
        check("R10 irq with enable cleared", ready_irq, 0);

        // R12 reset while idle returns mode to 00
        wr(2'd3, ctl(2'b10, 4'b0000));
        rst = 1'b1; repeat (2) @(negedge clk); rst = 1'b0;
        rd(2'd3, v);  check("R12 idle reset clears mode", v, 8'h00);

        // R12 reset during an erase keeps it running
        set_addr(9'h042);
        arm_fire(2'b00, 8'h12);
        busy_cycles(n);
        arm_fire(2'b01, 8'h00);
        repeat (3) @(negedge clk);
        rst = 1'b1; repeat (2) @(negedge clk); rst = 1'b0;
        rd(2'd3, v);
        check("R12 busy survives reset", v[1], 1);
        check("R12 mode kept through reset", v[5:4], 1);
        busy_cycles(n);
        read_byte(9'h042, v);  check("R12 erase completed after reset", v, 8'hFF);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule